// File: doc/BRIEF.md
# Motor Driver Protection Supervisor

This block watches the protection flags of a bridge-type motor driver and decides when the power stage has to be switched off. It takes raw flags for over-temperature, over-current, supply undervoltage and a supply-too-low-for-protection condition. Each raw flag passes through a two-flop synchronizer. The block also takes the enable input, a latch/auto-return select, the standby indication and a one-cycle marker that starts each chopping period. From these it drives an output-off command, a force-to-initial-position command and an active-low alert.

Over-current is always latched once it is confirmed, and a noise mask has to be satisfied before it is confirmed. Over-temperature either returns by itself at a chopping-period boundary or stays latched until re-enable, depending on the select input and the standby state. A latched fault is cleared only by an enable low pulse that lasts for a minimum number of clock cycles, or by the power-up reset. Undervoltage switches the outputs off and forces the initial position for as long as it lasts, and it needs no clearing.

Top module: `drv_fault_supervisor`

## Requirements
- R1: `outputOff` is 1 whenever `enableIn` is 0 or an over-temperature or over-current fault is held. `alertN` is 0 exactly while one of those two faults is held, and enable low by itself leaves `alertN` at 1.
- R2: With `autoReturn` at 1, a held over-temperature fault clears at the first cycle where `chopStart` is 1 and the synchronized temperature flag is already 0. A `chopStart` that arrives while the synchronized flag is still 1 does not clear it.
- R3: With `autoReturn` at 0 and `standby` at 0, over-temperature stays held until `enableIn` has been 0 for at least `MIN_LOW_CYCLES` consecutive clock edges and then returns to 1. A low pulse one cycle shorter has no effect. `chopStart` has no effect in this mode.
- R4: Over-current is accepted only after its synchronized flag has been 1 for `MASK_CYCLES` consecutive cycles. A shorter assertion is discarded.
- R5: A confirmed over-current stays held whatever `autoReturn` and `chopStart` do. It is cleared only by the qualified enable pulse of R3 or by `rstN`.
- R6: While `standby` is 1, over-current is never detected, and over-temperature returns automatically as in R2 even with `autoReturn` at 0.
- R7: While the synchronized low-supply flag is 1, neither over-temperature nor over-current can become held.
- R8: A qualified enable pulse does not clear over-temperature if the synchronized temperature flag is still 1 at the cycle where enable returns high.
- R9: While the synchronized undervoltage flag is 1, `outputOff` and `forceInit` are both 1 and `alertN` stays 1. Both release by themselves when the flag drops.
- R10: Each raw fault flag reaches the decision logic two clock edges after it changes. Undervoltage therefore shows at the outputs after two edges, and over-temperature becomes held at the third edge.
- R11: After reset with `enableIn` at 1 and all flags at 0, `outputOff` is 0, `forceInit` is 0 and `alertN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| otFlagRaw | input | 1 | Over-temperature sensor flag, unsynchronized |
| ocFlagRaw | input | 1 | Over-current sensor flag, unsynchronized |
| uvFlagRaw | input | 1 | Supply undervoltage flag, unsynchronized |
| lowSupplyRaw | input | 1 | Supply below protection threshold, unsynchronized |
| enableIn | input | 1 | Output enable, 1 means drive |
| autoReturn | input | 1 | 1: over-temperature returns by itself; 0: latched |
| standby | input | 1 | Standby indication |
| chopStart | input | 1 | One-cycle marker at the start of each chopping period |
| outputOff | output | 1 | Force the power stage off |
| forceInit | output | 1 | Force the step sequencer to its initial position |
| alertN | output | 1 | Active-low alert for a held thermal or current fault |

## Verification
Every result has a fixed latency from its stimulus. Undervoltage shows after two clock edges, because it only passes through the synchronizer. Over-temperature becomes held on the third edge. Over-current becomes held `MASK_CYCLES + 2` edges after its raw flag rises. A clear caused by enable or `chopStart` takes effect on the same edge that samples the releasing condition. The bench drives inputs on falling edges and advances an exact number of rising edges before it samples on a falling edge. Each check is placed both one cycle before and at the expected edge: for example, the over-current output is still clear after `MASK_CYCLES + 1` edges and set after `MASK_CYCLES + 2`, and the enable pulse is tried at one cycle below the minimum and then at exactly the minimum.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Strobes from the datapath towards the control.
  typedef struct packed {
    logic otFlag;       // synchronized over-temperature flag
    logic uvFlag;       // synchronized undervoltage flag
    logic lowSup;       // synchronized low-supply flag
    logic ocQualified;  // over-current survived the noise mask
    logic rearm;        // enable rose after a long enough low time
  } fsup_evt_t;

  // Strobes from the control back into the datapath.
  typedef struct packed {
    logic ocArm;        // over-current mask counter may run
  } fsup_arm_t;

endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= dIn[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign dOut = stage2;

endmodule

// File: rtl/fsup_datapath.sv
module fsup_datapath
  import fsup_pkg::*;
#(
  parameter int MASK_CYCLES    = 100,
  parameter int MIN_LOW_CYCLES = 30000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      otFlagRaw,
  input  logic      ocFlagRaw,
  input  logic      uvFlagRaw,
  input  logic      lowSupplyRaw,
  input  logic      enableIn,
  input  fsup_arm_t arm,
  output fsup_evt_t evt
);

  localparam int MASK_W = (MASK_CYCLES > 1) ? $clog2(MASK_CYCLES) : 1;
  localparam int LOW_W  = $clog2(MIN_LOW_CYCLES + 1);
  localparam logic [MASK_W-1:0] MASK_LAST = MASK_W'(MASK_CYCLES - 1);
  localparam logic [LOW_W-1:0]  LOW_FULL  = LOW_W'(MIN_LOW_CYCLES);

  // Synchronizer bit order: 0 ot, 1 oc, 2 uv, 3 low supply
  logic [3:0] rawFlags;
  logic [3:0] syncFlags;
  logic       ocSync;

  assign rawFlags = {lowSupplyRaw, uvFlagRaw, ocFlagRaw, otFlagRaw};

  fsup_sync #(.WIDTH(4)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn (rawFlags),
    .dOut(syncFlags)
  );

  assign ocSync = syncFlags[1];

  // Over-current noise mask: consecutive-cycle counter
  logic [MASK_W-1:0] maskCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskCnt <= '0;
    end else if (!(arm.ocArm && ocSync)) begin
      maskCnt <= '0;
    end else if (maskCnt != MASK_LAST) begin
      maskCnt <= maskCnt + 1'b1;
    end
  end

  // Enable low-time qualification
  logic [LOW_W-1:0] lowCnt;
  logic             enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      enPrev <= 1'b1;
    end else begin
      enPrev <= enableIn;
      if (enableIn) begin
        lowCnt <= '0;
      end else if (lowCnt != LOW_FULL) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  always_comb begin
    evt.otFlag      = syncFlags[0];
    evt.uvFlag      = syncFlags[2];
    evt.lowSup      = syncFlags[3];
    evt.ocQualified = arm.ocArm && ocSync && (maskCnt == MASK_LAST);
    evt.rearm       = enableIn && !enPrev && (lowCnt == LOW_FULL);
  end

  // R4: a qualified over-current needs the flag high in the previous cycle too
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    evt.ocQualified |-> $past(ocSync));

  // R3: re-arm only follows a cycle where enable was low
  p_rearm_after_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    evt.rearm |-> $past(!enableIn));

endmodule

// File: rtl/fsup_control.sv
module fsup_control
  import fsup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  fsup_evt_t evt,
  input  logic      autoReturn,
  input  logic      standby,
  input  logic      chopStart,
  output fsup_arm_t arm,
  output logic      otActive,
  output logic      ocActive
);

  logic autoMode;
  logic otSet;
  logic otClr;

  assign autoMode  = autoReturn || standby;
  assign otSet     = evt.otFlag && !evt.lowSup;
  assign otClr     = !evt.otFlag && ((autoMode && chopStart) || evt.rearm);
  assign arm.ocArm = !evt.lowSup && !standby;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otActive <= 1'b0;
    end else if (otSet) begin
      otActive <= 1'b1;
    end else if (otClr) begin
      otActive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocActive <= 1'b0;
    end else if (evt.ocQualified) begin
      ocActive <= 1'b1;
    end else if (evt.rearm) begin
      ocActive <= 1'b0;
    end
  end

  p_oc_needs_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocActive) |-> $past(evt.ocQualified));

  p_oc_clear_rearm_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ocActive) |-> $past(evt.rearm));

  p_ot_blocked_low_supply_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(otActive) |-> $past(!evt.lowSup));

  p_ot_clear_flag_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(otActive) |-> $past(!evt.otFlag));

  p_ot_latch_needs_rearm_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(otActive) && $past(!autoReturn && !standby)) |-> $past(evt.rearm));

  p_oc_standby_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocActive) |-> $past(!standby));

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int MASK_CYCLES    = 100,
  parameter int MIN_LOW_CYCLES = 30000
) (
  input  logic clk,
  input  logic rstN,
  input  logic otFlagRaw,
  input  logic ocFlagRaw,
  input  logic uvFlagRaw,
  input  logic lowSupplyRaw,
  input  logic enableIn,
  input  logic autoReturn,
  input  logic standby,
  input  logic chopStart,
  output logic outputOff,
  output logic forceInit,
  output logic alertN
);

  fsup_evt_t evt;
  fsup_arm_t arm;
  logic      otActive;
  logic      ocActive;

  fsup_datapath #(
    .MASK_CYCLES   (MASK_CYCLES),
    .MIN_LOW_CYCLES(MIN_LOW_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .otFlagRaw   (otFlagRaw),
    .ocFlagRaw   (ocFlagRaw),
    .uvFlagRaw   (uvFlagRaw),
    .lowSupplyRaw(lowSupplyRaw),
    .enableIn    (enableIn),
    .arm         (arm),
    .evt         (evt)
  );

  fsup_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .autoReturn(autoReturn),
    .standby   (standby),
    .chopStart (chopStart),
    .arm       (arm),
    .otActive  (otActive),
    .ocActive  (ocActive)
  );

  assign outputOff = !enableIn || otActive || ocActive || evt.uvFlag;
  assign forceInit = evt.uvFlag;
  assign alertN    = !(otActive || ocActive);

  // R9: undervoltage never raises the alert by itself
  p_uv_no_alert_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(evt.uvFlag) && $past(alertN)) |-> (alertN || $past(evt.otFlag || evt.ocQualified)));

endmodule

// File: tb/tb_drv_fault_supervisor.sv
module tb_drv_fault_supervisor;

  localparam int MASK = 8;
  localparam int MINLOW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic otFlagRaw = 1'b0, ocFlagRaw = 1'b0, uvFlagRaw = 1'b0, lowSupplyRaw = 1'b0;
  logic enableIn = 1'b1, autoReturn = 1'b1, standby = 1'b0, chopStart = 1'b0;
  logic outputOff, forceInit, alertN;

  int nTests = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  drv_fault_supervisor #(.MASK_CYCLES(MASK), .MIN_LOW_CYCLES(MINLOW)) dut (
    .clk(clk), .rstN(rstN), .otFlagRaw(otFlagRaw), .ocFlagRaw(ocFlagRaw),
    .uvFlagRaw(uvFlagRaw), .lowSupplyRaw(lowSupplyRaw), .enableIn(enableIn),
    .autoReturn(autoReturn), .standby(standby), .chopStart(chopStart),
    .outputOff(outputOff), .forceInit(forceInit), .alertN(alertN)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Compares {outputOff, forceInit, alertN}
  task automatic check(input string req, input logic [2:0] exp);
    nTests++;
    if ({outputOff, forceInit, alertN} !== exp) begin
      nFail++;
      $display("FAIL %s: got off/init/alertN=%b expected %b", req, {outputOff, forceInit, alertN}, exp);
    end
  endtask

  task automatic enPulse(input int lowCycles);
    enableIn = 1'b0;
    step(lowCycles);
    enableIn = 1'b1;
    step(1);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic t_reset_r11();
    doReset();
    check("R11 reset state", 3'b001);
  endtask

  task automatic t_enable_r1();
    enableIn = 1'b0; step(1);
    check("R1 enable low off, no alert", 3'b101);
    enableIn = 1'b1; step(1);
    check("R1 enable high drives", 3'b001);
  endtask

  task automatic t_uv_r9_r10();
    uvFlagRaw = 1'b1; step(1);
    check("R10 uv not yet through sync", 3'b001);
    step(1);
    check("R9 uv forces off and init", 3'b111);
    uvFlagRaw = 1'b0; step(2);
    check("R9 uv auto release", 3'b001);
  endtask

  task automatic t_ot_auto_r2();
    autoReturn = 1'b1;
    otFlagRaw = 1'b1; step(2);
    check("R10 ot not held after two edges", 3'b001);
    step(1);
    check("R1 ot held", 3'b100);
    otFlagRaw = 1'b0; step(1);
    chopStart = 1'b1; step(1);
    chopStart = 1'b0;
    check("R2 chop while sync flag high keeps fault", 3'b100);
    step(3);
    check("R2 no release without chop", 3'b100);
    chopStart = 1'b1; step(1);
    chopStart = 1'b0;
    check("R2 release at chop start", 3'b001);
  endtask

  task automatic t_ot_latch_r3();
    autoReturn = 1'b0;
    otFlagRaw = 1'b1; step(3);
    otFlagRaw = 1'b0; step(3);
    chopStart = 1'b1; step(1);
    chopStart = 1'b0;
    check("R3 chop ignored in latch mode", 3'b100);
    enPulse(MINLOW - 1);
    check("R3 short enable pulse ignored", 3'b100);
    enPulse(MINLOW);
    check("R3 qualified pulse clears", 3'b001);
  endtask

  task automatic t_ot_still_hot_r8();
    autoReturn = 1'b0;
    otFlagRaw = 1'b1; step(3);
    enPulse(MINLOW);
    check("R8 flag still high blocks clear", 3'b100);
    otFlagRaw = 1'b0; step(3);
    enPulse(MINLOW);
    check("R8 clears once flag low", 3'b001);
  endtask

  task automatic t_oc_mask_r4_r5();
    autoReturn = 1'b1;
    ocFlagRaw = 1'b1; step(MASK - 1);
    ocFlagRaw = 1'b0; step(MASK + 4);
    check("R4 short oc glitch rejected", 3'b001);
    ocFlagRaw = 1'b1; step(MASK + 1);
    check("R4 oc not yet confirmed", 3'b001);
    step(1);
    check("R4 oc confirmed after mask", 3'b100);
    ocFlagRaw = 1'b0; step(3);
    chopStart = 1'b1; step(1);
    chopStart = 1'b0;
    check("R5 oc stays latched in auto mode", 3'b100);
    enPulse(MINLOW - 1);
    check("R5 short pulse keeps oc", 3'b100);
    enPulse(MINLOW);
    check("R5 qualified pulse clears oc", 3'b001);
    ocFlagRaw = 1'b1; step(MASK + 2);
    ocFlagRaw = 1'b0;
    check("R5 oc latched again", 3'b100);
    doReset();
    check("R5 reset clears oc", 3'b001);
  endtask

  task automatic t_standby_r6();
    standby = 1'b1; autoReturn = 1'b0;
    ocFlagRaw = 1'b1; step(MASK + 10);
    ocFlagRaw = 1'b0; step(3);
    check("R6 oc ignored in standby", 3'b001);
    otFlagRaw = 1'b1; step(3);
    check("R6 ot held in standby", 3'b100);
    otFlagRaw = 1'b0; step(2);
    chopStart = 1'b1; step(1);
    chopStart = 1'b0;
    check("R6 ot auto-returns in standby", 3'b001);
    standby = 1'b0; step(1);
  endtask

  task automatic t_lowsup_r7();
    lowSupplyRaw = 1'b1; step(3);
    otFlagRaw = 1'b1; ocFlagRaw = 1'b1; step(MASK + 10);
    check("R7 no fault below supply threshold", 3'b001);
    otFlagRaw = 1'b0; ocFlagRaw = 1'b0; step(3);
    lowSupplyRaw = 1'b0; step(3);
    check("R7 still clear after supply returns", 3'b001);
  endtask

  initial begin
    t_reset_r11();
    t_enable_r1();
    t_uv_r9_r10();
    t_ot_auto_r2();
    t_ot_latch_r3();
    t_ot_still_hot_r8();
    t_oc_mask_r4_r5();
    t_standby_r6();
    t_lowsup_r7();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #1000000;
    nTests++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule